// File: doc/BRIEF.md
# Serial NOR Flash Single-Byte Read Sequencer

This block fetches one byte at a time from a serial NOR flash. Software sets it up through a small byte-wide register port. It writes the byte address into four address registers and the read opcodes into two opcode registers. It also sets the lane and address-width choices in a mode register and the fast-read choice in a configuration register. It then writes the start code into the command register. The sequencer drops chip select and shifts the opcode and address out on IO0. It adds eight dummy clocks where the chosen protocol calls for them, then gathers one data byte over one, two or four lanes.

Once chip select has been high again for at least one full SCK period, the received byte is copied into the read-data register and the command register returns to zero. Software polls the command register until its low five bits read zero, then reads the byte. The register port and the SPI pins are plain control pins. There is no streaming interface, so no valid/ready back-pressure applies.

SCK runs at half the system clock in SPI mode 0. It idles low, the flash samples on the rising edge, and the controller updates IO0 only while SCK is low.

Top module: `nor_byte_reader`

## Requirements
- R1: After reset the command and read-data registers read 0x00, spi_cs_n is 1, spi_sck is 0 and spi_io_oe is 4'b0000.
- R2: Writing 0x81 to the command register (offset 0x00) while it reads 0x00 starts one transfer. The register reads 0x81 while the transfer runs and returns to 0x00 in the same cycle that the received byte appears at the read-data register (offset 0x04). Writing any other value to offset 0x00 starts nothing, and the register keeps reading 0x00.
- R3: The address is held in byte registers at offsets 0x08 (bits 7:0), 0x0C (bits 15:8), 0x10 (bits 23:16) and 0x30 (bits 31:24). Each register reads back what was written. The address goes out on IO0 most significant bit first, directly after the opcode.
- R4: Mode register (offset 0x1C) bit 4 set sends 32 address bits. Clear, it sends only bits 23:0.
- R5: The opcode goes out on IO0 MSB first as the first 8 bits. It is taken from offset 0x18 in quad mode and from offset 0x14 otherwise.
- R6: Mode bit 2 selects quad-output read and takes priority over bit 0. Bit 0 alone selects dual-output read. With neither bit set, the read is single-line.
- R7: Configuration register (offset 0x20) bit 0 adds 8 dummy SCK cycles after the address on a single-line read. Dual and quad reads always have 8 dummy cycles. A single-line read with bit 0 clear has none.
- R8: Data is taken MSB first. A single-line read uses IO1 over 8 SCK cycles. A dual read uses {IO1,IO0} over 4 cycles. A quad read uses {IO3,IO2,IO1,IO0} over 2 cycles. The total SCK count per transfer is 8 + address bits + dummy cycles + data cycles.
- R9: SCK idles low, is high for exactly one system clock at a time, and spi_io_out does not change while SCK is high.
- R10: spi_cs_n stays low for the whole transfer, SCK stays low whenever spi_cs_n is high, and spi_cs_n is high for at least two system clocks before the command register clears.
- R11: A second start write during a transfer is ignored. The running transfer keeps its SCK count and result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr (combinational) |
| spi_sck | output | 1 | Serial clock, mode 0 |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_io_out | output | 4 | Values driven onto IO3..IO0 |
| spi_io_oe | output | 4 | Output enables for IO3..IO0 |
| spi_io_in | input | 4 | Values sampled from IO3..IO0 |

## Verification
The bench pairs a behavioural flash model with a table of transfers that walks every lane choice, both address widths, fast read on and off, and the case where both lane bits are set. If the lane priority were wrong, the wrong opcode would be sent and the SCK count would be off by two. If the dummy count were wrong, the data would shift by whole chunks. If the lanes were mapped the wrong way round, the nibbles or bit pairs would come back swapped. Directed cases cover three more faults: a 3-byte transfer that leaks the top address byte onto the wire, a non-start write that begins a transfer, and a second start write mid-transfer that restarts the sequencer and stretches the SCK count. A design that cleared the command before chip select had been high long enough would fail the measured gap.

// File: rtl/nor_rd_pkg.sv
package nor_rd_pkg;

  typedef enum logic [1:0] {
    LANE_X1 = 2'd0,
    LANE_X2 = 2'd1,
    LANE_X4 = 2'd2
  } lane_e;

  // register byte offsets
  localparam logic [7:0] OFS_CMD   = 8'h00;
  localparam logic [7:0] OFS_RDATA = 8'h04;
  localparam logic [7:0] OFS_ADR0  = 8'h08;
  localparam logic [7:0] OFS_OPC_A = 8'h14;
  localparam logic [7:0] OFS_OPC_Q = 8'h18;
  localparam logic [7:0] OFS_MODE  = 8'h1C;
  localparam logic [7:0] OFS_CFG   = 8'h20;
  localparam logic [7:0] OFS_ADR3  = 8'h30;

  localparam logic [7:0] CMD_START = 8'h81;

  // mode register bit positions
  localparam int MB_DUAL  = 0;
  localparam int MB_QUAD  = 2;
  localparam int MB_ADDR4 = 4;

  localparam int OPC_BITS  = 8;
  localparam int ADR_BYTES = 4;
  localparam int TX_W      = OPC_BITS + 8 * ADR_BYTES;
  localparam int TXC_W     = $clog2(TX_W + 1);

endpackage

// File: rtl/nor_rd_regs.sv
module nor_rd_regs
  import nor_rd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [7:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic        xfer_done,
  input  logic [7:0]  rx_byte,
  output logic        start,
  output logic [31:0] addr,
  output logic [7:0]  opc_a,
  output logic [7:0]  opc_q,
  output logic        mode_dual,
  output logic        mode_quad,
  output logic        mode_a4,
  output logic        fast
);

  logic [7:0] cmd_q, rdata_q, mode_q, opa_q, opq_q;
  logic       fast_q;

  // address byte registers; the top byte lives at its own offset
  for (genvar gi = 0; gi < ADR_BYTES; gi++) begin : g_adr
    localparam logic [7:0] OFS = (gi == ADR_BYTES - 1) ? OFS_ADR3 : (OFS_ADR0 + 8'(4 * gi));
    logic [7:0] byte_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          byte_q <= '0;
      else if (reg_we && reg_addr == OFS)  byte_q <= reg_wdata;
    end
    assign addr[8*gi +: 8] = byte_q;
  end

  assign start = reg_we && (reg_addr == OFS_CMD) && (reg_wdata == CMD_START) && (cmd_q == 8'h00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      rdata_q <= '0;
      mode_q  <= '0;
      opa_q   <= '0;
      opq_q   <= '0;
      fast_q  <= 1'b0;
    end else begin
      if (xfer_done) begin
        cmd_q   <= 8'h00;
        rdata_q <= rx_byte;
      end else if (start) begin
        cmd_q   <= CMD_START;
      end
      if (reg_we) begin
        unique case (reg_addr)
          OFS_MODE:  mode_q <= reg_wdata;
          OFS_OPC_A: opa_q  <= reg_wdata;
          OFS_OPC_Q: opq_q  <= reg_wdata;
          OFS_CFG:   fast_q <= reg_wdata[0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (reg_addr)
      OFS_CMD:            reg_rdata = cmd_q;
      OFS_RDATA:          reg_rdata = rdata_q;
      OFS_ADR0:           reg_rdata = addr[7:0];
      OFS_ADR0 + 8'd4:    reg_rdata = addr[15:8];
      OFS_ADR0 + 8'd8:    reg_rdata = addr[23:16];
      OFS_ADR3:           reg_rdata = addr[31:24];
      OFS_OPC_A:          reg_rdata = opa_q;
      OFS_OPC_Q:          reg_rdata = opq_q;
      OFS_MODE:           reg_rdata = mode_q;
      OFS_CFG:            reg_rdata = {7'd0, fast_q};
      default:            reg_rdata = 8'h00;
    endcase
  end

  assign opc_a     = opa_q;
  assign opc_q     = opq_q;
  assign mode_dual = mode_q[MB_DUAL];
  assign mode_quad = mode_q[MB_QUAD];
  assign mode_a4   = mode_q[MB_ADDR4];
  assign fast      = fast_q;

  // R11: a start-code write while busy leaves the command value alone
  p_busy_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == OFS_CMD && cmd_q != 8'h00 && !xfer_done) |=> (cmd_q == $past(cmd_q)));

  // R2: an accepted start shows the start code in the command register
  p_start_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cmd_q == CMD_START));

  // R2: completion returns the command register to zero
  p_done_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> (cmd_q == 8'h00));

endmodule

// File: rtl/nor_rd_plan.sv
module nor_rd_plan
  import nor_rd_pkg::*;
(
  input  logic             mode_dual,
  input  logic             mode_quad,
  input  logic             mode_a4,
  input  logic             fast,
  input  logic [7:0]       opc_a,
  input  logic [7:0]       opc_q,
  input  logic [31:0]      addr,
  output logic [TX_W-1:0]  tx_vec,
  output logic [TXC_W-1:0] tx_clks,
  output logic             dummy_on,
  output lane_e            lane,
  output logic [3:0]       data_clks
);

  logic [7:0] opcode;

  always_comb begin
    // quad wins over dual when both bits are set
    if (mode_quad)      lane = LANE_X4;
    else if (mode_dual) lane = LANE_X2;
    else                lane = LANE_X1;

    opcode   = mode_quad ? opc_q : opc_a;
    dummy_on = mode_quad || mode_dual || fast;

    if (mode_a4) begin
      tx_vec  = {opcode, addr};
      tx_clks = TXC_W'(OPC_BITS + 32);
    end else begin
      tx_vec  = {opcode, addr[23:0], 8'h00};
      tx_clks = TXC_W'(OPC_BITS + 24);
    end

    unique case (lane)
      LANE_X4: data_clks = 4'd2;
      LANE_X2: data_clks = 4'd4;
      default: data_clks = 4'd8;
    endcase
  end

endmodule

// File: rtl/nor_rd_seq.sv
module nor_rd_seq
  import nor_rd_pkg::*;
#(
  parameter int DUMMY_CLKS = 8,
  parameter int GAP_CLKS   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [TX_W-1:0]  tx_vec,
  input  logic [TXC_W-1:0] tx_clks,
  input  logic             dummy_on,
  input  lane_e            lane,
  input  logic [3:0]       data_clks,
  input  logic [3:0]       io_in,
  output logic             sck,
  output logic             cs_n,
  output logic [3:0]       io_out,
  output logic [3:0]       io_oe,
  output logic             done,
  output logic [7:0]       rx_byte
);

  localparam int CNT_MAX = (TX_W > DUMMY_CLKS) ? ((TX_W > GAP_CLKS) ? TX_W : GAP_CLKS)
                                               : ((DUMMY_CLKS > GAP_CLKS) ? DUMMY_CLKS : GAP_CLKS);
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_TX, S_DUMMY, S_DATA, S_GAP} st_e;

  st_e              state;
  logic [TX_W-1:0]  tx_sr;
  logic [CNT_W-1:0] cnt, dclk_q;
  logic             ph, sck_q, cs_q, dummy_q;
  lane_e            lane_q;
  logic [7:0]       rx_sr, rx_next;

  always_comb begin
    unique case (lane_q)
      LANE_X4: rx_next = {rx_sr[3:0], io_in};
      LANE_X2: rx_next = {rx_sr[5:0], io_in[1:0]};
      default: rx_next = {rx_sr[6:0], io_in[1]};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      tx_sr   <= '0;
      cnt     <= '0;
      dclk_q  <= '0;
      ph      <= 1'b0;
      sck_q   <= 1'b0;
      cs_q    <= 1'b1;
      dummy_q <= 1'b0;
      lane_q  <= LANE_X1;
      rx_sr   <= '0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (start) begin
            tx_sr   <= tx_vec;
            cnt     <= CNT_W'(tx_clks);
            dclk_q  <= CNT_W'(data_clks);
            dummy_q <= dummy_on;
            lane_q  <= lane;
            cs_q    <= 1'b0;
            ph      <= 1'b0;
            state   <= S_TX;
          end
        end
        S_TX, S_DUMMY, S_DATA: begin
          if (!ph) begin
            // rising SCK: the flash and this block both sample here
            sck_q <= 1'b1;
            ph    <= 1'b1;
            if (state == S_DATA) rx_sr <= rx_next;
          end else begin
            // falling SCK: the next output bit is set up while SCK is low
            sck_q <= 1'b0;
            ph    <= 1'b0;
            if (state == S_TX) tx_sr <= {tx_sr[TX_W-2:0], 1'b0};
            if (cnt == CNT_W'(1)) begin
              if (state == S_TX && dummy_q) begin
                state <= S_DUMMY;
                cnt   <= CNT_W'(DUMMY_CLKS);
              end else if (state == S_DATA) begin
                state <= S_GAP;
                cs_q  <= 1'b1;
                cnt   <= CNT_W'(GAP_CLKS);
              end else begin
                state <= S_DATA;
                cnt   <= dclk_q;
              end
            end else begin
              cnt <= cnt - CNT_W'(1);
            end
          end
        end
        S_GAP: begin
          if (cnt == CNT_W'(1)) state <= S_IDLE;
          else                  cnt   <= cnt - CNT_W'(1);
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign done    = (state == S_GAP) && (cnt == CNT_W'(1));
  assign rx_byte = rx_sr;
  assign sck     = sck_q;
  assign cs_n    = cs_q;
  assign io_out  = {3'b000, tx_sr[TX_W-1]};
  assign io_oe   = (state == S_TX) ? 4'b0001 : 4'b0000;

  // R9: SCK high lasts one system clock
  p_sck_half_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sck |=> !sck);

  // R9: outputs do not move while SCK is high
  p_io_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> $stable(io_out));

  // R10: no SCK pulse outside chip select
  p_sck_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  // R10: chip select has been high at least two clocks at completion
  p_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && $past(cs_n)));

  initial begin
    if (GAP_CLKS < 2 || DUMMY_CLKS < 1) $error("nor_rd_seq: GAP_CLKS must be >= 2 and DUMMY_CLKS >= 1");
  end

endmodule

// File: rtl/nor_byte_reader.sv
module nor_byte_reader
  import nor_rd_pkg::*;
#(
  parameter int DUMMY_CLKS = 8,
  parameter int GAP_CLKS   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       spi_sck,
  output logic       spi_cs_n,
  output logic [3:0] spi_io_out,
  output logic [3:0] spi_io_oe,
  input  logic [3:0] spi_io_in
);

  logic             start, done, dual, quad, a4, fast, dummy_on;
  logic [31:0]      addr;
  logic [7:0]       opc_a, opc_q, rx_byte;
  logic [TX_W-1:0]  tx_vec;
  logic [TXC_W-1:0] tx_clks;
  logic [3:0]       data_clks;
  lane_e            lane;

  nor_rd_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_done(done),
    .rx_byte(rx_byte), .start(start), .addr(addr), .opc_a(opc_a),
    .opc_q(opc_q), .mode_dual(dual), .mode_quad(quad), .mode_a4(a4), .fast(fast)
  );

  nor_rd_plan u_plan (
    .mode_dual(dual), .mode_quad(quad), .mode_a4(a4), .fast(fast),
    .opc_a(opc_a), .opc_q(opc_q), .addr(addr), .tx_vec(tx_vec),
    .tx_clks(tx_clks), .dummy_on(dummy_on), .lane(lane), .data_clks(data_clks)
  );

  nor_rd_seq #(.DUMMY_CLKS(DUMMY_CLKS), .GAP_CLKS(GAP_CLKS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_vec(tx_vec),
    .tx_clks(tx_clks), .dummy_on(dummy_on), .lane(lane), .data_clks(data_clks),
    .io_in(spi_io_in), .sck(spi_sck), .cs_n(spi_cs_n), .io_out(spi_io_out),
    .io_oe(spi_io_oe), .done(done), .rx_byte(rx_byte)
  );

  // R10: IO0 is driven only inside chip select
  p_oe_in_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_io_oe != 4'b0000) |-> !spi_cs_n);

endmodule

// File: tb/nor_byte_reader_bench.sv
module nor_byte_reader_bench;
  import nor_rd_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       spi_sck, spi_cs_n;
  logic [3:0] spi_io_out, spi_io_oe;
  logic [3:0] io_in = 4'h0;

  int nchk = 0;
  int nerr = 0;

  always #10 clk = ~clk;

  nor_byte_reader u_nor_byte_reader (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_io_out(spi_io_out), .spi_io_oe(spi_io_oe),
    .spi_io_in(io_in)
  );

  // flash model settings, written only by the main initial block
  int         m_ab = 24;
  int         m_pre = 1000;
  int         m_lanes = 1;
  logic [7:0] m_byte = 8'h00;

  // flash model state, written only by the model process
  logic        cs_prev = 1'b1;
  int          k = 0;
  int          sck_cnt = 0;
  logic [39:0] cap = '0;
  logic [7:0]  sh;

  always @(spi_sck or spi_cs_n) begin
    if (spi_cs_n === 1'b0 && cs_prev) begin
      k = 0; cap = '0; sck_cnt = 0;
    end
    cs_prev = (spi_cs_n !== 1'b0);
    if (spi_cs_n === 1'b0) begin
      if (spi_sck === 1'b1) begin
        sck_cnt++;
        if (k < 8 + m_ab) cap = {cap[38:0], spi_io_out[0]};
        k++;
      end else if (k >= m_pre) begin
        sh = m_byte << ((k - m_pre) * m_lanes);
        case (m_lanes)
          1:       io_in = {2'b00, sh[7], 1'b0};
          2:       io_in = {2'b00, sh[7:6]};
          default: io_in = sh[7:4];
        endcase
      end
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // vector: mode, cfg, addr, opcode A, opcode Q, flash byte
  localparam int NV = 8;
  localparam logic [71:0] VEC [NV] = '{
    {8'h00, 8'h00, 32'h00123456, 8'h03, 8'h6B, 8'hA5},
    {8'h00, 8'h01, 32'h00ABCDEF, 8'h0B, 8'h6B, 8'h3C},
    {8'h01, 8'h00, 32'h00F0E1D2, 8'h3B, 8'h6B, 8'h96},
    {8'h04, 8'h00, 32'h00345678, 8'h3B, 8'h6B, 8'hC7},
    {8'h14, 8'h00, 32'h89ABCDEF, 8'h3B, 8'h6C, 8'h5E},
    {8'h10, 8'h00, 32'hC3000102, 8'h13, 8'h6B, 8'h81},
    {8'h05, 8'h00, 32'h00070809, 8'h3B, 8'hEB, 8'h2D},
    {8'h11, 8'h01, 32'h7E5A1234, 8'h3C, 8'h6C, 8'hF0}
  };

  task automatic run_vec(input logic [71:0] v, input int inj);
    logic [7:0] m, f, opa, opq, d, rv;
    logic [31:0] a;
    logic q, du;
    int ab, dummy, lanes, exp_sck, cs_hi_at, done_at;
    bit seen_low, fin;
    m = v[71:64]; f = v[63:56]; a = v[55:24]; opa = v[23:16]; opq = v[15:8]; d = v[7:0];
    q = m[2]; du = !q && m[0];
    ab = m[4] ? 32 : 24;
    dummy = (q || du || f[0]) ? 8 : 0;
    lanes = q ? 4 : (du ? 2 : 1);
    exp_sck = 8 + ab + dummy + 8 / lanes;
    m_ab = ab; m_pre = 8 + ab + dummy; m_lanes = lanes; m_byte = d;
    wr(OFS_MODE, m); wr(OFS_CFG, f);
    wr(OFS_ADR0, a[7:0]); wr(OFS_ADR0 + 8'd4, a[15:8]);
    wr(OFS_ADR0 + 8'd8, a[23:16]); wr(OFS_ADR3, a[31:24]);
    wr(OFS_OPC_A, opa); wr(OFS_OPC_Q, opq);
    wr(OFS_CMD, CMD_START);
    seen_low = 0; fin = 0; cs_hi_at = -1; done_at = -1;
    for (int n = 0; n < 400 && !fin; n++) begin
      @(negedge clk);
      if (n == inj) begin
        reg_we = 1'b1; reg_wdata = CMD_START;
      end else begin
        reg_we = 1'b0;
      end
      reg_addr = OFS_CMD;
      #1;
      if (n == 0) check("R2 busy readback", reg_rdata, CMD_START);
      if (!spi_cs_n) seen_low = 1;
      if (spi_cs_n && seen_low && cs_hi_at < 0) cs_hi_at = n;
      if (reg_rdata == 8'h00) begin fin = 1; done_at = n; end
    end
    reg_we = 1'b0;
    check("R2 command clears", fin, 1'b1);
    check("R5 opcode on IO0", q ? opq : opa, (ab == 32) ? cap[39:32] : cap[31:24]);
    check("R3 R4 address bits", (ab == 32) ? cap[31:0] : {8'h00, cap[23:0]},
          (ab == 32) ? a : {8'h00, a[23:0]});
    check("R7 R8 R11 sck count", sck_cnt, exp_sck);
    check("R10 cs gap", (cs_hi_at >= 0) && (done_at - cs_hi_at >= 2), 1'b1);
    rd(OFS_RDATA, rv);
    check("R6 R8 read byte", rv, d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [7:0] rv;
    bit cs_moved;
    repeat (3) @(negedge clk);
    // R1 reset state
    reg_addr = OFS_CMD; #1 check("R1 cmd at reset", reg_rdata, 8'h00);
    reg_addr = OFS_RDATA; #1 check("R1 rdata at reset", reg_rdata, 8'h00);
    check("R1 cs_n at reset", spi_cs_n, 1'b1);
    check("R1 sck at reset", spi_sck, 1'b0);
    check("R1 oe at reset", spi_io_oe, 4'b0000);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 address byte readback, top byte at its own offset
    wr(OFS_ADR3, 8'h5C); wr(OFS_ADR0 + 8'd8, 8'hA7);
    rd(OFS_ADR3, rv); check("R3 top address byte readback", rv, 8'h5C);
    rd(OFS_ADR0 + 8'd8, rv); check("R3 third address byte readback", rv, 8'hA7);

    // R2 a non-start value starts nothing
    wr(OFS_CMD, 8'h02);
    cs_moved = 0;
    for (int n = 0; n < 20; n++) begin
      @(negedge clk);
      if (spi_cs_n !== 1'b1 || spi_sck !== 1'b0) cs_moved = 1;
    end
    check("R2 non-start write idle", cs_moved, 1'b0);
    rd(OFS_CMD, rv); check("R2 non-start reads zero", rv, 8'h00);

    // table walk
    for (int i = 0; i < NV; i++) run_vec(VEC[i], -1);

    // R11 second start during a dual read and during a quad read
    run_vec(VEC[2], 15);
    run_vec(VEC[4], 40);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule